// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor-side request port and a cache controller and keeps a record of every memory request that is in flight. Each request is sorted by its operation code into one of two small associative tables, one for write-class operations and one for read-class operations. Both tables are keyed by the cache-line address, which is the request address with its byte-offset bits dropped. A new request is checked for a legal size, then for a line collision in either table, then for room. It is answered one cycle later with one of four status codes, and accepted requests are entered together with the cycle they arrived.

A completion names a line and the table it belongs to, and frees the matching entry. A completion with no match raises an error pulse and leaves the state alone. Four counters record collisions. Each is chosen by which table held the blocking line and by the kind of incoming operation. A periodic age check raises a sticky deadlock flag when any entry has waited at least a configured number of cycles. The check runs only while the tracker holds requests.

Top module: `mreq_tracker`

## Requirements
- R1: After a synchronous reset, resp_valid, resp_status, outstanding, cpl_err, deadlock and all four stall counters are zero, and empty is high.
- R2: Operation codes 2 (store), 3 (atomic read), 4 (atomic write), 5 (reserved read) and 6 (conditional write) belong to the write table. Codes 0 (load) and 1 (instruction fetch) belong to the read table. The line of a request is req_addr shifted right by log2(LINE_BYTES).
- R3: A request whose byte offset plus req_len exceeds LINE_BYTES, or whose code is 7, is answered 3 (bad). It allocates nothing and touches no counter.
- R4: A legal request whose line is held in the write table is answered 1 (aliased). It adds one to stall_wblk_rd when its code is 0, 1 or 3, and to stall_wblk_wr otherwise.
- R5: A legal request whose line is absent from the write table but held in the read table is answered 1 (aliased). It adds one to stall_rblk_wr when its code is 2 or 4, and to stall_rblk_rd otherwise.
- R6: Collisions take precedence over capacity. A legal request with no collision is answered 2 (full) when outstanding is at least MAX_OUT or its table has no free entry. Otherwise it is answered 0 (ready) and allocated, and outstanding never exceeds MAX_OUT.
- R7: resp_valid and resp_status appear on the cycle after req_valid is sampled, and resp_valid is low otherwise.
- R8: A completion (cpl_valid, with cpl_write=1 selecting the write table) whose line is held in that table frees the entry and lowers outstanding by one. A request and a completion in the same cycle both see the table contents from before that cycle.
- R9: A completion with no matching entry in the selected table drives cpl_err high for one cycle and leaves outstanding unchanged.
- R10: outstanding always equals the number of held entries, and empty is high exactly when outstanding is zero.
- R11: When an entry is allocated and no check is pending, an age check is scheduled THRESH cycles later. At the check, deadlock is set and stays set until reset if any entry is at least THRESH cycles old. The check re-arms THRESH cycles later only while entries remain; otherwise it goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | ADDR_W | Physical byte address |
| req_len | input | LEN_W | Access length in bytes |
| cpl_valid | input | 1 | Completion this cycle |
| cpl_write | input | 1 | 1: completion targets write table, 0: read table |
| cpl_line | input | ADDR_W-log2(LINE_BYTES) | Line address being completed |
| resp_valid | output | 1 | Status valid for the previous request |
| resp_status | output | 2 | 0 ready, 1 aliased, 2 full, 3 bad |
| outstanding | output | CNT_W | Number of held entries |
| empty | output | 1 | No entries held |
| cpl_err | output | 1 | Previous completion matched nothing |
| deadlock | output | 1 | Sticky age-check failure |
| stall_wblk_rd | output | STALL_W | Read-like request blocked by write entry |
| stall_wblk_wr | output | STALL_W | Other request blocked by write entry |
| stall_rblk_wr | output | STALL_W | Store-like request blocked by read entry |
| stall_rblk_rd | output | STALL_W | Other request blocked by read entry |

## Verification
The hardest case to reach is a deadlock that the first scheduled check misses. Here the entry that started the schedule has already completed, and a younger entry arrived while the check was still pending. That younger entry must then be caught one full interval later. Directed sequences place the first completion and the second request at fixed cycles and confirm that the flag stays low through the first check and rises exactly at the second. Random traffic over a handful of lines, with completions steered to the oldest entry, exercises collisions, both capacity limits and orphan completions while keeping the flag low.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_IFETCH  = 3'd1,
    OP_STORE   = 3'd2,
    OP_RMW_RD  = 3'd3,
    OP_RMW_WR  = 3'd4,
    OP_RSV_RD  = 3'd5,
    OP_COND_WR = 3'd6,
    OP_NONE    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_ALIAS = 2'd1,
    ST_FULL  = 2'd2,
    ST_BAD   = 2'd3
  } status_e;

  localparam int TBL_RD = 0;
  localparam int TBL_WR = 1;

  // write-class operations live in the write table
  function automatic logic op_to_wr_table(op_e op);
    return (op == OP_STORE) || (op == OP_RMW_RD) || (op == OP_RMW_WR) ||
           (op == OP_RSV_RD) || (op == OP_COND_WR);
  endfunction

  // incoming kinds that count as "read-like" when a write entry blocks them
  function automatic logic op_read_like(op_e op);
    return (op == OP_LOAD) || (op == OP_IFETCH) || (op == OP_RMW_RD);
  endfunction

  // incoming kinds that count as "store-like" when a read entry blocks them
  function automatic logic op_store_like(op_e op);
    return (op == OP_STORE) || (op == OP_RMW_WR);
  endfunction

endpackage

// File: rtl/mrt_table.sv
module mrt_table #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26,
  parameter int TIME_W = 20,
  parameter int THRESH = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] look_line,
  output logic              look_hit,
  output logic              has_free,
  input  logic              alloc,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic [TIME_W-1:0] now,
  input  logic              rel,
  input  logic [LINE_W-1:0] rel_line,
  output logic              rel_hit,
  output logic              aged
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [TIME_W-1:0] THR = TIME_W'(THRESH);

  logic [DEPTH-1:0]  vld_q;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [TIME_W-1:0] born_q [DEPTH];

  logic [IDX_W-1:0] rel_idx;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    look_hit = 1'b0;
    rel_hit  = 1'b0;
    has_free = 1'b0;
    aged     = 1'b0;
    rel_idx  = '0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && (line_q[i] == look_line)) look_hit = 1'b1;
      if (vld_q[i] && (line_q[i] == rel_line)) begin
        rel_hit = 1'b1;
        rel_idx = IDX_W'(i);
      end
      if (!vld_q[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (vld_q[i] && ((now - born_q[i]) >= THR)) aged = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (rel && rel_hit) vld_q[rel_idx] <= 1'b0;
      if (alloc) vld_q[free_idx] <= 1'b1;
    end
  end

  // payload storage carries no reset
  always_ff @(posedge clk) begin
    if (alloc) begin
      line_q[free_idx] <= alloc_line;
      born_q[free_idx] <= now;
    end
  end

endmodule

// File: rtl/mrt_watchdog.sv
module mrt_watchdog #(
  parameter int TIME_W = 20,
  parameter int THRESH = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic              busy_next,
  input  logic              any_aged,
  output logic [TIME_W-1:0] now,
  output logic              deadlock
);
  localparam logic [TIME_W-1:0] THR = TIME_W'(THRESH);

  logic [TIME_W-1:0] now_q;
  logic [TIME_W-1:0] due_q;
  logic              pending_q;
  logic              fire;

  assign fire = pending_q && (now_q == due_q);
  assign now  = now_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q     <= '0;
      due_q     <= '0;
      pending_q <= 1'b0;
      deadlock  <= 1'b0;
    end else begin
      now_q <= now_q + 1'b1;
      if (fire) begin
        if (any_aged) deadlock <= 1'b1;
        pending_q <= busy_next;
        due_q     <= now_q + THR;
      end else if (alloc && !pending_q) begin
        pending_q <= 1'b1;
        due_q     <= now_q + THR;
      end
    end
  end

endmodule

// File: rtl/mrt_stalls.sv
module mrt_stalls #(
  parameter int NUM     = 4,
  parameter int STALL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM-1:0]     ev,
  output logic [STALL_W-1:0] cnt [NUM]
);
  for (genvar k = 0; k < NUM; k++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (rst)        cnt[k] <= '0;
      else if (ev[k]) cnt[k] <= cnt[k] + 1'b1;
    end
  end
endmodule

// File: rtl/mreq_tracker.sv
module mreq_tracker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 7,
  parameter int RD_DEPTH   = 8,
  parameter int WR_DEPTH   = 8,
  parameter int MAX_OUT    = 12,
  parameter int TIME_W     = 20,
  parameter int THRESH     = 500000,
  parameter int STALL_W    = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int CNT_W     = $clog2(RD_DEPTH + WR_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               cpl_valid,
  input  logic               cpl_write,
  input  logic [LINE_W-1:0]  cpl_line,
  output logic               resp_valid,
  output logic [1:0]         resp_status,
  output logic [CNT_W-1:0]   outstanding,
  output logic               empty,
  output logic               cpl_err,
  output logic               deadlock,
  output logic [STALL_W-1:0] stall_wblk_rd,
  output logic [STALL_W-1:0] stall_wblk_wr,
  output logic [STALL_W-1:0] stall_rblk_wr,
  output logic [STALL_W-1:0] stall_rblk_rd
);
  import mrt_pkg::*;

  op_e               op;
  logic [LINE_W-1:0] req_line;
  logic [OFF_W-1:0]  req_off;
  logic              legal;
  logic              to_wr;
  logic              cap_ok;
  logic              accept;
  logic              released;
  status_e           status_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_next;
  logic [TIME_W-1:0] now;

  logic [1:0] look_hit;
  logic [1:0] has_free;
  logic [1:0] rel_hit;
  logic [1:0] aged;
  logic [1:0] alloc;
  logic [1:0] rel;

  logic [3:0]         stall_ev;
  logic [STALL_W-1:0] stall_cnt [4];

  assign op       = op_e'(req_op);
  assign req_line = req_addr[ADDR_W-1:OFF_W];
  assign req_off  = req_addr[OFF_W-1:0];
  assign to_wr    = op_to_wr_table(op);
  assign legal    = (op != OP_NONE) &&
                    ((32'(req_off) + 32'(req_len)) <= 32'(LINE_BYTES));
  assign cap_ok   = (32'(cnt_q) < 32'(MAX_OUT)) && has_free[to_wr];

  always_comb begin
    if (!legal)                 status_d = ST_BAD;
    else if (look_hit[TBL_WR])  status_d = ST_ALIAS;
    else if (look_hit[TBL_RD])  status_d = ST_ALIAS;
    else if (!cap_ok)           status_d = ST_FULL;
    else                        status_d = ST_READY;
  end

  assign accept   = req_valid && (status_d == ST_READY);
  assign released = cpl_valid && rel_hit[cpl_write];
  assign cnt_next = cnt_q + CNT_W'(accept) - CNT_W'(released);

  // one table per request class
  for (genvar g = 0; g < 2; g++) begin : g_tbl
    localparam int DEP = (g == TBL_RD) ? RD_DEPTH : WR_DEPTH;
    assign alloc[g] = accept && (32'(to_wr) == g);
    assign rel[g]   = cpl_valid && (32'(cpl_write) == g);
    mrt_table #(
      .DEPTH (DEP),
      .LINE_W(LINE_W),
      .TIME_W(TIME_W),
      .THRESH(THRESH)
    ) u_tbl (
      .clk       (clk),
      .rst       (rst),
      .look_line (req_line),
      .look_hit  (look_hit[g]),
      .has_free  (has_free[g]),
      .alloc     (alloc[g]),
      .alloc_line(req_line),
      .now       (now),
      .rel       (rel[g]),
      .rel_line  (cpl_line),
      .rel_hit   (rel_hit[g]),
      .aged      (aged[g])
    );
  end

  mrt_watchdog #(
    .TIME_W(TIME_W),
    .THRESH(THRESH)
  ) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .alloc    (accept),
    .busy_next(cnt_next != '0),
    .any_aged (|aged),
    .now      (now),
    .deadlock (deadlock)
  );

  // collision classification
  always_comb begin
    stall_ev = '0;
    if (req_valid && legal) begin
      if (look_hit[TBL_WR]) begin
        stall_ev[0] = op_read_like(op);
        stall_ev[1] = !op_read_like(op);
      end else if (look_hit[TBL_RD]) begin
        stall_ev[2] = op_store_like(op);
        stall_ev[3] = !op_store_like(op);
      end
    end
  end

  mrt_stalls #(
    .NUM    (4),
    .STALL_W(STALL_W)
  ) u_stalls (
    .clk(clk),
    .rst(rst),
    .ev (stall_ev),
    .cnt(stall_cnt)
  );

  assign stall_wblk_rd = stall_cnt[0];
  assign stall_wblk_wr = stall_cnt[1];
  assign stall_rblk_wr = stall_cnt[2];
  assign stall_rblk_rd = stall_cnt[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      empty       <= 1'b1;
      resp_valid  <= 1'b0;
      resp_status <= 2'd0;
      cpl_err     <= 1'b0;
    end else begin
      cnt_q       <= cnt_next;
      empty       <= (cnt_next == '0);
      resp_valid  <= req_valid;
      resp_status <= req_valid ? status_d : ST_READY;
      cpl_err     <= cpl_valid && !rel_hit[cpl_write];
    end
  end

  assign outstanding = cnt_q;

endmodule

// File: rtl/mrt_checker.sv
module mrt_checker #(
  parameter int MAX_OUT = 12,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             cpl_valid,
  input logic             resp_valid,
  input logic [1:0]       resp_status,
  input logic [CNT_W-1:0] outstanding,
  input logic             empty,
  input logic             cpl_err,
  input logic             deadlock
);

  assert_resp_follows_req_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  assert_no_resp_without_req_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    32'(outstanding) <= MAX_OUT);

  assert_empty_flag_R10: assert property (@(posedge clk) disable iff (rst)
    empty == (outstanding == '0));

  assert_reject_keeps_cnt_R6: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && (resp_status != 2'd0) && !$past(cpl_valid))
      |-> (outstanding == $past(outstanding)));

  assert_orphan_keeps_cnt_R9: assert property (@(posedge clk) disable iff (rst)
    (cpl_err && !(resp_valid && (resp_status == 2'd0)))
      |-> (outstanding == $past(outstanding)));

  assert_deadlock_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    $past(deadlock) |-> deadlock);

endmodule

bind mreq_tracker mrt_checker #(
  .MAX_OUT(MAX_OUT),
  .CNT_W  (CNT_W)
) u_mrt_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .cpl_valid  (cpl_valid),
  .resp_valid (resp_valid),
  .resp_status(resp_status),
  .outstanding(outstanding),
  .empty      (empty),
  .cpl_err    (cpl_err),
  .deadlock   (deadlock)
);

// File: tb/mreq_tracker_bench.sv
`timescale 1ns/1ps
module mreq_tracker_bench;
  localparam int ADDR_W = 12;
  localparam int LB     = 16;
  localparam int LEN_W  = 5;
  localparam int RDD    = 4;
  localparam int WRD    = 4;
  localparam int MAXO   = 6;
  localparam int TW     = 12;
  localparam int THR    = 40;
  localparam int SW     = 16;
  localparam int LW     = ADDR_W - 4;
  localparam int CW     = $clog2(RDD + WRD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic cpl_valid = 1'b0;
  logic cpl_write = 1'b0;
  logic [LW-1:0] cpl_line = '0;
  logic resp_valid;
  logic [1:0] resp_status;
  logic [CW-1:0] outstanding;
  logic empty, cpl_err, deadlock;
  logic [SW-1:0] s_wrd, s_wwr, s_rwr, s_rrd;

  always #2 clk = ~clk;

  mreq_tracker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LB), .LEN_W(LEN_W), .RD_DEPTH(RDD),
    .WR_DEPTH(WRD), .MAX_OUT(MAXO), .TIME_W(TW), .THRESH(THR), .STALL_W(SW)
  ) u_mreq_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .cpl_valid(cpl_valid),
    .cpl_write(cpl_write), .cpl_line(cpl_line), .resp_valid(resp_valid),
    .resp_status(resp_status), .outstanding(outstanding), .empty(empty),
    .cpl_err(cpl_err), .deadlock(deadlock), .stall_wblk_rd(s_wrd),
    .stall_wblk_wr(s_wwr), .stall_rblk_wr(s_rwr), .stall_rblk_rd(s_rrd)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model
  int rq[$];
  int wq[$];
  int rage[$];
  int wage[$];
  int m_st[4];
  int exp_dl = 0;

  task automatic check_eq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int find(ref int q[$], input int line);
    foreach (q[i]) if (q[i] == line) return i;
    return -1;
  endfunction

  function automatic bit is_wr_op(int op);
    return (op >= 2) && (op <= 6);
  endfunction

  task automatic model_clear();
    rq.delete(); wq.delete(); rage.delete(); wage.delete();
    for (int i = 0; i < 4; i++) m_st[i] = 0;
    exp_dl = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    cpl_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    check_eq("R1 resp_valid", int'(resp_valid), 0);
    check_eq("R1 resp_status", int'(resp_status), 0);
    check_eq("R1 outstanding", int'(outstanding), 0);
    check_eq("R1 empty", int'(empty), 1);
    check_eq("R1 cpl_err", int'(cpl_err), 0);
    check_eq("R1 deadlock", int'(deadlock), 0);
    check_eq("R1 stalls", int'(s_wrd) + int'(s_wwr) + int'(s_rwr) + int'(s_rrd), 0);
  endtask

  // one cycle: drive at negedge, predict, check after the edge
  task automatic step(input bit rv, input int op, input int addr, input int len,
                      input bit cv, input bit cw, input int cl, input string tag);
    int line, off, st, e_err, idx;
    bit wr;
    req_valid = rv; req_op = op[2:0]; req_addr = addr[ADDR_W-1:0];
    req_len = len[LEN_W-1:0];
    cpl_valid = cv; cpl_write = cw; cpl_line = cl[LW-1:0];
    line = addr >> 4; off = addr & 15; wr = is_wr_op(op);
    st = 0; e_err = 0;
    if (rv) begin
      if (op == 7 || off + len > LB) st = 3;
      else if (find(wq, line) >= 0) begin
        st = 1;
        if (op == 0 || op == 1 || op == 3) m_st[0]++; else m_st[1]++;
      end else if (find(rq, line) >= 0) begin
        st = 1;
        if (op == 2 || op == 4) m_st[2]++; else m_st[3]++;
      end else if (rq.size() + wq.size() >= MAXO ||
                   (wr ? wq.size() >= WRD : rq.size() >= RDD)) st = 2;
    end
    if (cv) begin
      if (cw) begin
        idx = find(wq, cl);
        if (idx >= 0) begin wq.delete(idx); wage.delete(idx); end else e_err = 1;
      end else begin
        idx = find(rq, cl);
        if (idx >= 0) begin rq.delete(idx); rage.delete(idx); end else e_err = 1;
      end
    end
    if (rv && st == 0) begin
      if (wr) begin wq.push_back(line); wage.push_back(0); end
      else    begin rq.push_back(line); rage.push_back(0); end
    end
    @(posedge clk); #1;
    check_eq({tag, " R7 resp_valid"}, int'(resp_valid), int'(rv));
    if (rv) check_eq({tag, " R3/R4/R5/R6 status"}, int'(resp_status), st);
    check_eq({tag, " R8/R10 outstanding"}, int'(outstanding), rq.size() + wq.size());
    check_eq({tag, " R10 empty"}, int'(empty), (rq.size() + wq.size()) == 0);
    check_eq({tag, " R9 cpl_err"}, int'(cpl_err), e_err);
    check_eq({tag, " R4 stall_wblk_rd"}, int'(s_wrd), m_st[0]);
    check_eq({tag, " R4 stall_wblk_wr"}, int'(s_wwr), m_st[1]);
    check_eq({tag, " R5 stall_rblk_wr"}, int'(s_rwr), m_st[2]);
    check_eq({tag, " R5 stall_rblk_rd"}, int'(s_rrd), m_st[3]);
    check_eq({tag, " R11 deadlock"}, int'(deadlock), exp_dl);
    foreach (rage[i]) rage[i]++;
    foreach (wage[i]) wage[i]++;
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0, 0, 0, "idle");
  endtask

  task automatic drain();
    while (wq.size() > 0) step(0, 0, 0, 1, 1, 1, wq[0], "drain R8");
    while (rq.size() > 0) step(0, 0, 0, 1, 1, 0, rq[0], "drain R8");
  endtask

  initial begin
    #(4ns * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog timeout");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // R2 / R4 / R5 collisions and classification
    step(1, 2, 'h050, 4, 0, 0, 0, "R2 store line5");
    step(1, 0, 'h052, 2, 0, 0, 0, "R4 load vs write");
    step(1, 2, 'h058, 1, 0, 0, 0, "R4 store vs write");
    step(1, 3, 'h050, 1, 0, 0, 0, "R4 rmw rd vs write");
    step(1, 1, 'h060, 8, 0, 0, 0, "R2 ifetch line6");
    step(1, 2, 'h060, 1, 0, 0, 0, "R5 store vs read");
    step(1, 4, 'h061, 1, 0, 0, 0, "R5 rmw wr vs read");
    step(1, 1, 'h062, 1, 0, 0, 0, "R5 ifetch vs read");
    step(1, 5, 'h063, 1, 0, 0, 0, "R5 rsv rd vs read");
    // R3 bad size / code
    step(1, 0, 'h07C, 5, 0, 0, 0, "R3 oversize");
    step(1, 7, 'h080, 1, 0, 0, 0, "R3 code7");
    step(1, 0, 'h07C, 4, 0, 0, 0, "R3 exact fit");
    // R2: reserved read is write-class
    step(1, 5, 'h090, 1, 0, 0, 0, "R2 rsv rd");
    step(0, 0, 0, 1, 1, 0, 9, "R2 wrong table R9");
    step(0, 0, 0, 1, 1, 1, 9, "R2 rsv rd release R8");
    // R8 same-cycle completion and request on one line
    step(1, 0, 'h050, 1, 1, 1, 5, "R8 same cycle");
    step(1, 0, 'h050, 1, 0, 0, 0, "R8 after release");
    // R9 orphan
    step(0, 0, 0, 1, 1, 1, 200, "R9 orphan");
    drain();

    // R6 capacity: write table fills first, then global limit
    for (int i = 0; i < WRD; i++) step(1, 2, (16 + i) << 4, 1, 0, 0, 0, "R6 fill wr");
    step(1, 6, 30 << 4, 1, 0, 0, 0, "R6 wr table full");
    step(1, 0, 31 << 4, 1, 0, 0, 0, "R6 load ok");
    step(1, 1, 32 << 4, 1, 0, 0, 0, "R6 load ok");
    step(1, 0, 33 << 4, 1, 0, 0, 0, "R6 max reached");
    step(1, 0, 16 << 4, 1, 0, 0, 0, "R6 alias beats full");
    step(1, 0, 31 << 4, 1, 0, 0, 0, "R6 read alias beats full");
    step(1, 0, 33 << 4, 1, 1, 0, 31, "R6 full with release");
    drain();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit rv, cv, cw;
      int op, line, off, len, cl, oldest, owr, oi;
      rv = ($urandom % 100) < 70;
      op = ($urandom % 50 == 0) ? 7 : int'($urandom % 7);
      line = $urandom % 8;
      off = $urandom % 16;
      len = ($urandom % 10 == 0) ? 1 + int'($urandom % 16) : 1 + int'($urandom % (16 - off));
      cv = 0; cw = 0; cl = 0;
      oldest = -1; owr = 0; oi = 0;
      foreach (wage[i]) if (wage[i] > oldest) begin oldest = wage[i]; owr = 1; oi = i; end
      foreach (rage[i]) if (rage[i] > oldest) begin oldest = rage[i]; owr = 0; oi = i; end
      if (oldest > 20) begin
        cv = 1; cw = owr; cl = owr ? wq[oi] : rq[oi];
      end else if (($urandom % 100) < 55) begin
        cv = 1;
        if ($urandom % 20 == 0) begin cw = $urandom % 2; cl = 100; end
        else if (wq.size() > 0 && ($urandom % 2 == 0 || rq.size() == 0)) begin
          cw = 1; cl = wq[$urandom % wq.size()];
        end else if (rq.size() > 0) begin
          cw = 0; cl = rq[$urandom % rq.size()];
        end else begin cw = 0; cl = 101; end
      end
      step(rv, op, (line << 4) | off, len, cv, cw, cl, "rand");
    end
    drain();
    idle(3 * THR);

    // R11 exact threshold
    do_reset();
    step(1, 0, 'h010, 1, 0, 0, 0, "R11 arm");
    idle(THR - 1);
    exp_dl = 1;
    step(0, 0, 0, 1, 0, 0, 0, "R11 at threshold");
    idle(5);

    // R11 late entry caught one interval later
    do_reset();
    step(1, 0, 'h010, 1, 0, 0, 0, "R11 arm A");
    idle(4);
    step(0, 0, 0, 1, 1, 0, 1, "R11 release A");
    idle(24);
    step(1, 2, 'h020, 1, 0, 0, 0, "R11 insert B");
    idle(49);
    exp_dl = 1;
    step(0, 0, 0, 1, 0, 0, 0, "R11 second check");

    // R11 idle when empty
    do_reset();
    step(1, 1, 'h030, 1, 0, 0, 0, "R11 short life");
    idle(4);
    step(0, 0, 0, 1, 1, 0, 3, "R11 release");
    idle(3 * THR);
    step(1, 1, 'h040, 1, 0, 0, 0, "R11 rearm");
    idle(THR - 2);
    step(0, 0, 0, 1, 1, 0, 4, "R11 release in time");
    idle(2 * THR);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule